// File: doc/BRIEF.md
# Itemset Support Counter with Transaction Address List

This block measures the support of one candidate itemset: the number of database transactions that hold every item of the candidate. Transactions live in an external memory as bit vectors, split into a fixed number of narrower words. Each stored bit is inverted, so a 1 means the item is absent. For each word the block issues a read, masks the returned word with the matching slice of the candidate, and counts the transaction when every slice comes back all zero. When the scan ends it raises a one-cycle completion pulse and reports the count and whether the count reaches the supplied threshold.

Because candidates arrive in depth-first order, a candidate at depth d+1 is always a child of the last candidate seen at depth d. The block stores the addresses of the transactions that matched a frequent candidate in a small on-chip list, tagged by depth. A child candidate then reads only those transactions instead of the whole database. When a level's addresses do not fit, that level is marked unusable and its children fall back to a full scan. Starting a candidate discards every stored level at or below its own depth in the tree.

Top module: `itemset_support_counter`

## Requirements
- R1: After reset `done`, `memRd`, `support` and `frequent` are all 0.
- R2: Chunk k of transaction t sits at memory word t*NB_BLOCK+k and holds items k*CHUNK_W to k*CHUNK_W+CHUNK_W-1, each stored inverted (1 = item absent). A transaction is counted only when, for every chunk, the stored word ANDed with the candidate slice is zero.
- R3: Each chunk takes four cycles. A read is requested (`memRd` high for one cycle) in its first cycle, and the data is taken from `memRdata` in the following cycle. Requests run in transaction order and then in chunk order, so the i-th request of a scan is seen at the (4i+1)-th clock edge after the start edge.
- R4: `done` is high for exactly one cycle, 4*T*NB_BLOCK clock edges after the edge that accepts `start`, where T is the number of transactions read.
- R5: `support` saturates at 2^CNT_W-1 and never wraps.
- R6: While `done` is high and until the next accepted start, `support` holds the count and `frequent` is 1 exactly when `support` >= `threshold`.
- R7: After a frequent candidate at depth d whose matches fit, a candidate at depth d+1 reads only those matching transactions, in ascending order.
- R8: A candidate at depth 0, or one whose depth-(d-1) level is not retained (the parent was infrequent), reads all `dbSize` transactions.
- R9: All levels share one list of LIST_DEPTH entries. Depth d writes right after the end of what depth d-1 retained. If the matches do not fit, depth d is not retained and its child scans the full database.
- R10: Accepting a candidate at depth d discards every retained level >= d.
- R11: `start` is ignored while a scan is in progress. The running scan's result and timing are unchanged, and no new scan follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a candidate (accepted only when idle) |
| candidate | input | ITEM_W | Candidate itemset bit vector |
| threshold | input | CNT_W | Minimum support for frequent |
| dbSize | input | ADDR_W+1 | Number of transactions in the database |
| depth | input | LVL_W | Tree depth of the candidate |
| done | output | 1 | One-cycle completion pulse |
| support | output | CNT_W | Saturating support count |
| frequent | output | 1 | Support reached the threshold |
| memRd | output | 1 | Memory read request |
| memAddr | output | ADDR_W+CH_W | Memory word address |
| memRdata | input | CHUNK_W | Read data, valid in the cycle after the request |

## Verification
A wrong match accumulator or counter shows up as a wrong `support` or `frequent` on the completion pulse of that same candidate. A corrupted address list, or a level that is retained or evicted when it should not be, shows up one candidate later: the child's read addresses change, and so does the number of cycles before `done`, since the scan length is exactly four cycles per chunk. The bench therefore compares every request address and the cycle on which it appears against a model of which transactions each depth should read. This exposes a fault in the list at the first read that departs from the model.

// File: rtl/isc_pkg.sv
package isc_pkg;
  // cycles spent on every memory chunk
  localparam int CHUNK_CYC = 4;

  typedef struct packed {
    logic scanStart;   // candidate accepted
    logic memRd;       // read request cycle
    logic chunkLatch;  // read data is present
    logic txCommit;    // last chunk of a transaction resolved
    logic enterFin;    // scan completes at the coming edge
  } iscStrobe_t;
endpackage

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
#(
  parameter int NB_BLOCK = 2,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 13,
  parameter int CH_W     = 1,
  parameter int MEM_AW   = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  numTxIn,
  input  logic [ADDR_W-1:0] txAddr,
  output iscStrobe_t        strb,
  output logic [CH_W-1:0]   chunkIdx,
  output logic [IDX_W-1:0]  txIdx,
  output logic [MEM_AW-1:0] memAddr,
  output logic              done
);
  localparam int PH_W = $clog2(CHUNK_CYC);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} ctrlState_t;

  ctrlState_t       state, nextState;
  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] numTxQ;
  logic             lastChunk, lastTx, phaseEnd;

  always_comb begin
    lastChunk = (chunkIdx == CH_W'(NB_BLOCK - 1));
    lastTx    = (txIdx == numTxQ - IDX_W'(1));
    phaseEnd  = (phase == PH_W'(CHUNK_CYC - 1));
    nextState = state;
    case (state)
      ST_IDLE: if (start) nextState = (numTxIn == '0) ? ST_FIN : ST_SCAN;
      ST_SCAN: if (phaseEnd && lastChunk && lastTx) nextState = ST_FIN;
      default: nextState = ST_IDLE;
    endcase
    strb.scanStart  = (state == ST_IDLE) && start;
    strb.memRd      = (state == ST_SCAN) && (phase == PH_W'(0));
    strb.chunkLatch = (state == ST_SCAN) && (phase == PH_W'(1));
    strb.txCommit   = (state == ST_SCAN) && (phase == PH_W'(2)) && lastChunk;
    strb.enterFin   = (nextState == ST_FIN) && (state != ST_FIN);
  end

  assign done    = (state == ST_FIN);
  assign memAddr = MEM_AW'(txAddr) * MEM_AW'(NB_BLOCK) + MEM_AW'(chunkIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      chunkIdx <= '0;
      txIdx    <= '0;
      numTxQ   <= '0;
    end else begin
      state <= nextState;
      if (strb.scanStart) begin
        numTxQ   <= numTxIn;
        phase    <= '0;
        chunkIdx <= '0;
        txIdx    <= '0;
      end else if (state == ST_SCAN) begin
        phase <= phaseEnd ? '0 : phase + PH_W'(1);
        if (phaseEnd) begin
          if (lastChunk) begin
            chunkIdx <= '0;
            txIdx    <= txIdx + IDX_W'(1);
          end else begin
            chunkIdx <= chunkIdx + CH_W'(1);
          end
        end
      end
    end
  end

  // R3: a read is followed by three quiet cycles
  p_read_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.memRd |=> !strb.memRd ##1 !strb.memRd ##1 !strb.memRd);

  // R4: completion is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: the scan length is frozen while scanning
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |=> $stable(numTxQ));
endmodule

// File: rtl/isc_datapath.sv
module isc_datapath
  import isc_pkg::*;
#(
  parameter int ITEM_W   = 32,
  parameter int NB_BLOCK = 2,
  parameter int CHUNK_W  = 16,
  parameter int CH_W     = 1,
  parameter int CNT_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  iscStrobe_t         strb,
  input  logic [CH_W-1:0]    chunkIdx,
  input  logic [ITEM_W-1:0]  candidate,
  input  logic [CNT_W-1:0]   threshold,
  input  logic [CHUNK_W-1:0] memRdata,
  output logic               txHit,
  output logic               freqNow,
  output logic [CNT_W-1:0]   support,
  output logic               frequent
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ITEM_W-1:0]  candQ;
  logic [CNT_W-1:0]   thrQ, countQ;
  logic               passAcc, haveResult, chunkClear;
  logic [CHUNK_W-1:0] candChunks [NB_BLOCK];
  logic [CHUNK_W-1:0] candChunk;

  for (genvar g = 0; g < NB_BLOCK; g++) begin : g_slice
    assign candChunks[g] = candQ[g*CHUNK_W +: CHUNK_W];
  end

  assign candChunk  = candChunks[chunkIdx];
  // stored words are inverted: any surviving bit is a missing item
  assign chunkClear = ((memRdata & candChunk) == '0);
  assign txHit      = strb.txCommit && passAcc;
  assign freqNow    = (countQ >= thrQ);
  assign support    = countQ;
  assign frequent   = haveResult && freqNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candQ      <= '0;
      thrQ       <= '0;
      countQ     <= '0;
      passAcc    <= 1'b0;
      haveResult <= 1'b0;
    end else if (strb.scanStart) begin
      candQ      <= candidate;
      thrQ       <= threshold;
      countQ     <= '0;
      passAcc    <= 1'b1;
      haveResult <= strb.enterFin;
    end else begin
      if (strb.chunkLatch)
        passAcc <= ((chunkIdx == '0) ? 1'b1 : passAcc) & chunkClear;
      if (txHit && (countQ != CNT_MAX))
        countQ <= countQ + CNT_W'(1);
      if (strb.enterFin)
        haveResult <= 1'b1;
    end
  end

  // R2: a transaction with a failing chunk leaves the count alone
  p_miss_no_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txCommit && !passAcc) |=> $stable(countQ));

  // R5: the count never drops within a scan
  p_support_monotone_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.scanStart |=> countQ >= $past(countQ));

  // R5: a saturated count stays saturated
  p_saturate_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == CNT_MAX && !strb.scanStart) |=> countQ == CNT_MAX);

  // R6: a published result is held until the next start
  p_freq_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (haveResult && !strb.scanStart) |=> $stable(frequent) && $stable(support));
endmodule

// File: rtl/isc_addr_list.sv
module isc_addr_list
  import isc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int IDX_W      = 13,
  parameter int LIST_DEPTH = 64,
  parameter int LIST_W     = 7,
  parameter int LEVELS     = 8,
  parameter int LVL_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  iscStrobe_t        strb,
  input  logic [LVL_W-1:0]  depth,
  input  logic [IDX_W-1:0]  dbSize,
  input  logic [IDX_W-1:0]  txIdx,
  input  logic              txHit,
  input  logic              freqNow,
  output logic [IDX_W-1:0]  numTxIn,
  output logic [ADDR_W-1:0] txAddr
);
  localparam int MI_W = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1;

  logic [ADDR_W-1:0] listMem [LIST_DEPTH];
  logic              lvlValid [LEVELS];
  logic [LIST_W-1:0] lvlBase  [LEVELS];
  logic [LIST_W-1:0] lvlEnd   [LEVELS];

  logic [LVL_W-1:0]  depthQ, depthM1;
  logic [LIST_W-1:0] wrPtr, wrBaseQ, srcBaseQ, wrBase, rdIdx, newEnd;
  logic              ovf, srcValidQ, parentOk, keepIt;

  always_comb begin
    depthM1  = depth - LVL_W'(1);
    parentOk = (depth != '0) && lvlValid[depthM1];
    wrBase   = (depth == '0) ? '0 : lvlEnd[depthM1];
    numTxIn  = parentOk ? IDX_W'(lvlEnd[depthM1] - lvlBase[depthM1]) : dbSize;
    rdIdx    = srcBaseQ + LIST_W'(txIdx);
    if (!srcValidQ)                    txAddr = txIdx[ADDR_W-1:0];
    else if (rdIdx < LIST_W'(LIST_DEPTH)) txAddr = listMem[rdIdx[MI_W-1:0]];
    else                               txAddr = '0;
    keepIt = freqNow && !ovf;
    newEnd = keepIt ? wrPtr : wrBaseQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthQ    <= '0;
      wrPtr     <= '0;
      wrBaseQ   <= '0;
      srcBaseQ  <= '0;
      srcValidQ <= 1'b0;
      ovf       <= 1'b0;
    end else if (strb.scanStart) begin
      depthQ    <= depth;
      srcValidQ <= parentOk;
      srcBaseQ  <= lvlBase[depthM1];
      wrPtr     <= wrBase;
      wrBaseQ   <= wrBase;
      ovf       <= 1'b0;
    end else if (txHit) begin
      if (wrPtr < LIST_W'(LIST_DEPTH)) wrPtr <= wrPtr + LIST_W'(1);
      else                             ovf   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!strb.scanStart && txHit && (wrPtr < LIST_W'(LIST_DEPTH)))
      listMem[wrPtr[MI_W-1:0]] <= txAddr;
  end

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lvlValid[lv] <= 1'b0;
        lvlBase[lv]  <= '0;
        lvlEnd[lv]   <= '0;
      end else if (strb.scanStart) begin
        if (LVL_W'(lv) >= depth) lvlValid[lv] <= 1'b0;
      end else if (strb.enterFin && (LVL_W'(lv) >= depthQ)) begin
        lvlEnd[lv] <= newEnd;
        if (LVL_W'(lv) == depthQ) begin
          lvlBase[lv]  <= wrBaseQ;
          lvlValid[lv] <= keepIt;
        end
      end
    end
  end

  // R9: the write pointer never passes the list capacity
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= LIST_W'(LIST_DEPTH));

  // R9: once lost, a level stays lost for the rest of its scan
  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !strb.scanStart) |=> ovf);

  // R10: the accepted depth is not retained right after the start
  p_evict_on_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.scanStart |=> !lvlValid[depthQ]);
endmodule

// File: rtl/itemset_support_counter.sv
module itemset_support_counter
  import isc_pkg::*;
#(
  parameter int ITEM_W     = 32,
  parameter int NB_BLOCK   = 2,
  parameter int ADDR_W     = 12,
  parameter int LIST_DEPTH = 64,
  parameter int CNT_W      = 16,
  parameter int LEVELS     = 8,
  localparam int CHUNK_W   = ITEM_W / NB_BLOCK,
  localparam int CH_W      = (NB_BLOCK > 1) ? $clog2(NB_BLOCK) : 1,
  localparam int IDX_W     = ADDR_W + 1,
  localparam int MEM_AW    = ADDR_W + CH_W,
  localparam int LIST_W    = $clog2(LIST_DEPTH + 1),
  localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ITEM_W-1:0]  candidate,
  input  logic [CNT_W-1:0]   threshold,
  input  logic [IDX_W-1:0]   dbSize,
  input  logic [LVL_W-1:0]   depth,
  output logic               done,
  output logic [CNT_W-1:0]   support,
  output logic               frequent,
  output logic               memRd,
  output logic [MEM_AW-1:0]  memAddr,
  input  logic [CHUNK_W-1:0] memRdata
);
  iscStrobe_t        strb;
  logic [CH_W-1:0]   chunkIdx;
  logic [IDX_W-1:0]  txIdx, numTxIn;
  logic [ADDR_W-1:0] txAddr;
  logic              txHit, freqNow;

  assign memRd = strb.memRd;

  isc_ctrl #(
    .NB_BLOCK(NB_BLOCK), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .CH_W(CH_W), .MEM_AW(MEM_AW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .numTxIn(numTxIn),
    .txAddr(txAddr), .strb(strb), .chunkIdx(chunkIdx), .txIdx(txIdx),
    .memAddr(memAddr), .done(done)
  );

  isc_datapath #(
    .ITEM_W(ITEM_W), .NB_BLOCK(NB_BLOCK), .CHUNK_W(CHUNK_W),
    .CH_W(CH_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .chunkIdx(chunkIdx),
    .candidate(candidate), .threshold(threshold), .memRdata(memRdata),
    .txHit(txHit), .freqNow(freqNow), .support(support), .frequent(frequent)
  );

  isc_addr_list #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LIST_DEPTH(LIST_DEPTH),
    .LIST_W(LIST_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) list_i (
    .clk(clk), .rstN(rstN), .strb(strb), .depth(depth), .dbSize(dbSize),
    .txIdx(txIdx), .txHit(txHit), .freqNow(freqNow),
    .numTxIn(numTxIn), .txAddr(txAddr)
  );
endmodule

// File: tb/itemset_support_counter_tb_top.sv
`timescale 1ns/1ps
module itemset_support_counter_tb_top;
  localparam int DB    = 10;
  localparam int CAP   = 8;
  localparam int SAT   = 7;
  localparam int LOGN  = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] candidate = '0;
  logic [2:0] threshold = '0;
  logic [4:0] dbSize = 5'(DB);
  logic [1:0] depth = '0;
  logic       done, frequent, memRd;
  logic [2:0] support;
  logic [4:0] memAddr;
  logic [3:0] memRdata = '0;

  int checks = 0, fails = 0, cyc = 0, reqN = 0;
  bit finished = 1'b0;
  int reqAddr [LOGN];
  int reqEdge [LOGN];
  logic [7:0] txItems [16];
  logic [3:0] store [32];

  bit mValid [4];
  int mEnd [4];
  int mCnt [4];
  int mList [4][16];

  itemset_support_counter #(
    .ITEM_W(8), .NB_BLOCK(2), .ADDR_W(4), .LIST_DEPTH(CAP), .CNT_W(3), .LEVELS(4)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .candidate(candidate),
    .threshold(threshold), .dbSize(dbSize), .depth(depth), .done(done),
    .support(support), .frequent(frequent), .memRd(memRd),
    .memAddr(memAddr), .memRdata(memRdata)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memRd) begin
      memRdata <= store[memAddr];
      reqAddr[reqN % LOGN] <= int'(memAddr);
      reqEdge[reqN % LOGN] <= cyc + 1;
      reqN <= reqN + 1;
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic runCand(string tag, logic [7:0] cand, int thr, int dep, bit poke = 1'b0);
    int src [16];
    int hits [16];
    int nSrc = 0, nHit = 0, sup, wbase, s, reqBase, bad = 0, w = 0, nowReq;
    bit freq, keep;
    if (dep > 0 && mValid[dep-1]) begin
      for (int i = 0; i < mCnt[dep-1]; i++) src[nSrc++] = mList[dep-1][i];
    end else begin
      for (int i = 0; i < DB; i++) src[nSrc++] = i;
    end
    for (int l = dep; l < 4; l++) mValid[l] = 1'b0;
    for (int i = 0; i < nSrc; i++)
      if ((txItems[src[i]] & cand) == cand) hits[nHit++] = src[i];
    sup   = (nHit > SAT) ? SAT : nHit;
    freq  = (sup >= thr);
    wbase = (dep == 0) ? 0 : mEnd[dep-1];
    keep  = freq && (wbase + nHit <= CAP);

    @(negedge clk);
    start = 1'b1; candidate = cand; threshold = 3'(thr); depth = 2'(dep);
    @(negedge clk);
    start = 1'b0;
    s = cyc;
    reqBase = reqN;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; candidate = ~cand; depth = 2'd0; threshold = 3'd0;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && w < 5000) begin
      @(negedge clk);
      w++;
    end
    check(done == 1'b1, {tag, " R4 done seen"}, int'(done), 1);
    check(cyc - s == 8 * nSrc, {tag, " R4 scan cycles"}, cyc - s, 8 * nSrc);
    check(support == 3'(sup), {tag, " R2 R5 support"}, int'(support), sup);
    check(frequent == freq, {tag, " R6 frequent"}, int'(frequent), int'(freq));
    for (int i = 0; i < nSrc; i++)
      for (int k = 0; k < 2; k++) begin
        int idx = (reqBase + 2*i + k) % LOGN;
        if (reqAddr[idx] != src[i]*2 + k || reqEdge[idx] != s + 4*(2*i + k) + 1) bad++;
      end
    check(bad == 0 && reqN - reqBase == 2 * nSrc, {tag, " R3 R7 R8 read sequence"},
          reqN - reqBase, 2 * nSrc);
    nowReq = reqN;
    repeat (3) @(negedge clk);
    check(!done && support == 3'(sup) && frequent == freq && reqN == nowReq,
          {tag, " R6 R11 result held, no new scan"}, int'(support), sup);
    for (int l = dep; l < 4; l++) mEnd[l] = keep ? wbase + nHit : wbase;
    mValid[dep] = keep;
    mCnt[dep] = nHit;
    for (int i = 0; i < nHit; i++) mList[dep][i] = hits[i];
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(!done && !memRd && support == '0 && !frequent, "R1 reset outputs",
          int'({done, memRd, support, frequent}), 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_chunks();
    runCand("R2 both chunks", 8'h13, 3, 0);
    runCand("R2 upper chunk", 8'hF0, 1, 0);
    runCand("R8 depth zero", 8'h03, 4, 0);
  endtask

  task automatic test_saturate_overflow();
    runCand("R5 saturate", 8'h00, 7, 0);
    runCand("R9 overflow child", 8'h01, 1, 1);
  endtask

  task automatic test_list_reuse();
    runCand("R7 root", 8'h80, 2, 0);
    runCand("R7 child", 8'h81, 2, 1);
    runCand("R7 grandchild", 8'h83, 1, 2);
  endtask

  task automatic test_infrequent_parent();
    runCand("R8 weak parent", 8'h40, 5, 0);
    runCand("R8 child full", 8'h41, 1, 1);
  endtask

  task automatic test_evict();
    runCand("R10 root", 8'h80, 2, 0);
    runCand("R10 child", 8'h81, 2, 1);
    runCand("R10 new root", 8'h01, 2, 0);
    runCand("R10 deep after evict", 8'h83, 1, 2);
  endtask

  task automatic test_busy_start();
    runCand("R11 start while busy", 8'h30, 2, 0, 1'b1);
  endtask

  initial begin
    logic [7:0] db [DB];
    db = '{8'h0F, 8'h33, 8'h3F, 8'h81, 8'hF0, 8'h07, 8'h13, 8'hFF, 8'h03, 8'h30};
    for (int i = 0; i < 16; i++) txItems[i] = (i < DB) ? db[i] : 8'h00;
    for (int i = 0; i < 16; i++) begin
      store[2*i]     = ~txItems[i][3:0];
      store[2*i + 1] = ~txItems[i][7:4];
    end
    for (int l = 0; l < 4; l++) begin
      mValid[l] = 1'b0; mEnd[l] = 0; mCnt[l] = 0;
    end
    test_reset();
    test_chunks();
    test_saturate_overflow();
    test_list_reuse();
    test_infrequent_parent();
    test_evict();
    test_busy_start();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule